// File: doc/BRIEF.md
# I2C Master Byte-Boundary Stall and Stop Controller

This block is the flow-control part of an I2C master. The bit engine raises a one-cycle indication whenever it is about to start the first bit of a byte. At that moment the controller looks at the enable state and at the levels of the transmit and receive FIFOs. It then decides whether the engine should carry on, hold SCL low (a stall), or close the transfer with a STOP. The decision is registered, so it reaches the bit engine one cycle after the byte boundary. A stall is re-evaluated on every cycle and is released as soon as its cause goes away.

A master that has been switched off, either by its enable going low or by a mode-entry disable request, never stalls. It keeps sending whatever is still queued for transmit, and once the transmit FIFO runs dry it requests a STOP by itself. The block also keeps track of which timing set the bit engine should use. After a high-speed master code has been sent, the next repeated START moves the engine to the high-speed set. The engine goes back to the normal set when the STOP completes. A busy output covers the span from START to the end of STOP.

Top module: `i2c_mstall_ctrl`

## Requirements
- R1: During and right after reset, busy_o, stall_o, stop_req_o and hs_sel_o are all 0.
- R2: A start_i pulse sets busy_o from the next cycle. A stop_done_i pulse clears it from the next cycle. If both arrive in the same cycle, busy_o ends up 1.
- R3: While busy and not already stalled, a stall or STOP decision is taken only in a cycle where byte_bound_i is 1. The decision appears on the outputs in the following cycle. Input changes in other cycles have no effect.
- R4: The master is active when enable_i=1 and mode_dis_i=0. If the master is active, tx_empty_i=1 and auto_stop_i=0 at a boundary, stall_o goes to 1.
- R5: If the master is active, receiving_i=1, rx_discard_i=0 and rx_full_i=1 at a boundary, stall_o goes to 1. With rx_discard_i=1 there is no stall for a full receive FIFO.
- R6: While stalled, the conditions are checked on every cycle. stall_o stays at 1 while a stall cause holds and falls in the cycle after the cause clears.
- R7: If the master is active, tx_empty_i=1, auto_stop_i=1 and no receive stall applies at a boundary, stop_req_o goes to 1 instead of a stall.
- R8: When the master is not active, stall_o never rises. An existing stall is dropped on the next evaluation. A boundary with tx_empty_i=0 continues with no STOP. A boundary (or a stalled cycle) with tx_empty_i=1 raises stop_req_o.
- R9: stop_req_o stays at 1 until stop_done_i. While it is pending no stall is raised. stop_done_i clears stall_o and stop_req_o.
- R10: An hs_code_i pulse while busy arms the high-speed switch. The next start_i then sets hs_sel_o to 1. stop_done_i clears hs_sel_o and the armed state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| enable_i | input | 1 | Master enable |
| mode_dis_i | input | 1 | Disable request on mode entry |
| byte_bound_i | input | 1 | Bit engine is at the first bit of a byte |
| start_i | input | 1 | START or repeated START issued |
| stop_done_i | input | 1 | STOP condition completed |
| hs_code_i | input | 1 | High-speed master code byte finished |
| tx_empty_i | input | 1 | Transmit FIFO empty |
| rx_full_i | input | 1 | Receive FIFO full |
| receiving_i | input | 1 | Current byte is a receive byte |
| rx_discard_i | input | 1 | Current receive byte is being discarded |
| auto_stop_i | input | 1 | Issue STOP rather than stall on empty transmit FIFO |
| busy_o | output | 1 | Transfer in progress from START to STOP completion |
| stall_o | output | 1 | Hold SCL low |
| stop_req_o | output | 1 | Generate a STOP |
| hs_sel_o | output | 1 | 1 selects the high-speed timing set |

## Verification
A wrong stall flag shows up at the ports in the very next cycle, as a held SCL that should be free or a free SCL that should be held. So a comparison on every clock pins a fault to the boundary that caused it. A lost or stuck pending-STOP state appears either as stop_req_o missing one cycle after the empty boundary, or as a stall rising while a STOP is outstanding. A corrupted armed high-speed state stays hidden until the next START, where hs_sel_o rises or fails to rise. The bench therefore always follows a master code with a repeated START, and also sends STARTs without a master code.

// File: rtl/i2c_mstall_pkg.sv
package i2c_mstall_pkg;

    typedef enum logic [1:0] {
        DEC_GO   = 2'd0,
        DEC_HOLD = 2'd1,
        DEC_STOP = 2'd2
    } byte_dec_e;

    typedef struct packed {
        logic busy;
        logic stall;
        logic stop;
    } ctrl_state_t;

    typedef struct packed {
        logic armed;
        logic sel;
    } speed_state_t;

    localparam ctrl_state_t  CTRL_RESET  = '0;
    localparam speed_state_t SPEED_RESET = '0;

endpackage

// File: rtl/i2c_mstall_decide.sv
module i2c_mstall_decide
    import i2c_mstall_pkg::*;
(
    input  logic      active_i,
    input  logic      tx_empty_i,
    input  logic      auto_stop_i,
    input  logic      receiving_i,
    input  logic      rx_discard_i,
    input  logic      rx_full_i,
    output byte_dec_e dec_o
);
    logic tx_hold;
    logic rx_hold;

    always_comb begin
        tx_hold = tx_empty_i && !auto_stop_i;
        rx_hold = receiving_i && !rx_discard_i && rx_full_i;
        dec_o   = DEC_GO;
        if (active_i) begin
            if (tx_hold || rx_hold) begin
                dec_o = DEC_HOLD;
            end else if (tx_empty_i) begin
                dec_o = DEC_STOP;
            end
        end else if (tx_empty_i) begin
            dec_o = DEC_STOP;
        end
    end
endmodule

// File: rtl/i2c_mstall_speed.sv
module i2c_mstall_speed
    import i2c_mstall_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic busy_i,
    input  logic start_i,
    input  logic stop_done_i,
    input  logic hs_code_i,
    output logic hs_sel_o
);
    speed_state_t sp_d, sp_q;

    always_comb begin
        sp_d = sp_q;
        if (stop_done_i) begin
            sp_d = SPEED_RESET;
        end else begin
            if (start_i && sp_q.armed) begin
                sp_d.sel   = 1'b1;
                sp_d.armed = 1'b0;
            end else if (hs_code_i && busy_i) begin
                sp_d.armed = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            sp_q <= SPEED_RESET;
        end else begin
            sp_q <= sp_d;
        end
    end

    assign hs_sel_o = sp_q.sel;
endmodule

// File: rtl/i2c_mstall_ctrl.sv
module i2c_mstall_ctrl
    import i2c_mstall_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic enable_i,
    input  logic mode_dis_i,
    input  logic byte_bound_i,
    input  logic start_i,
    input  logic stop_done_i,
    input  logic hs_code_i,
    input  logic tx_empty_i,
    input  logic rx_full_i,
    input  logic receiving_i,
    input  logic rx_discard_i,
    input  logic auto_stop_i,
    output logic busy_o,
    output logic stall_o,
    output logic stop_req_o,
    output logic hs_sel_o
);
    ctrl_state_t st_d, st_q;
    byte_dec_e   dec;
    logic        active;
    logic        eval_en;

    assign active = enable_i && !mode_dis_i;

    i2c_mstall_decide u_decide (
        .active_i     (active),
        .tx_empty_i   (tx_empty_i),
        .auto_stop_i  (auto_stop_i),
        .receiving_i  (receiving_i),
        .rx_discard_i (rx_discard_i),
        .rx_full_i    (rx_full_i),
        .dec_o        (dec)
    );

    always_comb begin
        st_d    = st_q;
        // a held bus is re-judged every cycle, otherwise only at byte edges
        eval_en = st_q.busy && !st_q.stop && (byte_bound_i || st_q.stall);
        st_d.stall = eval_en && (dec == DEC_HOLD);
        st_d.stop  = st_q.stop || (eval_en && (dec == DEC_STOP));
        if (stop_done_i) begin
            st_d = CTRL_RESET;
        end
        if (start_i) begin
            st_d.busy = 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= CTRL_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    i2c_mstall_speed u_speed (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .busy_i      (st_q.busy),
        .start_i     (start_i),
        .stop_done_i (stop_done_i),
        .hs_code_i   (hs_code_i),
        .hs_sel_o    (hs_sel_o)
    );

    assign busy_o     = st_q.busy;
    assign stall_o    = st_q.stall;
    assign stop_req_o = st_q.stop;
endmodule

// File: rtl/i2c_mstall_chk.sv
module i2c_mstall_chk (
    input logic clk_i,
    input logic rst_ni,
    input logic enable_i,
    input logic mode_dis_i,
    input logic byte_bound_i,
    input logic start_i,
    input logic stop_done_i,
    input logic tx_empty_i,
    input logic busy_o,
    input logic stall_o,
    input logic stop_req_o,
    input logic hs_sel_o
);
    // R8
    stall_needs_active_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stall_o |-> $past(enable_i && !mode_dis_i));

    // R3
    stall_rise_at_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(stall_o) |-> $past(byte_bound_i) && $past(busy_o));

    // R9
    stall_stop_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(stall_o && stop_req_o));

    // R7
    stop_rise_on_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(stop_req_o) |-> $past(tx_empty_i));

    // R2
    stop_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stop_done_i && !start_i |=> !busy_o && !stall_o && !stop_req_o && !hs_sel_o);

    // R10
    hs_rise_on_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(hs_sel_o) |-> $past(start_i));
endmodule

bind i2c_mstall_ctrl i2c_mstall_chk u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .enable_i     (enable_i),
    .mode_dis_i   (mode_dis_i),
    .byte_bound_i (byte_bound_i),
    .start_i      (start_i),
    .stop_done_i  (stop_done_i),
    .tx_empty_i   (tx_empty_i),
    .busy_o       (busy_o),
    .stall_o      (stall_o),
    .stop_req_o   (stop_req_o),
    .hs_sel_o     (hs_sel_o)
);

// File: tb/i2c_mstall_ctrl_test.sv
module i2c_mstall_ctrl_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0, mdis = 1'b0, bb = 1'b0, st = 1'b0, spd = 1'b0, hsc = 1'b0;
    logic txe = 1'b0, rxf = 1'b0, rcv = 1'b0, disc = 1'b0, aus = 1'b0;
    logic busy, stall, stopr, hs;

    int checks = 0;
    int errors = 0;
    string cur = "R1";

    // behavioural reference state
    bit m_busy, m_stall, m_stop, m_armed, m_hs;

    always #5 clk = ~clk;

    i2c_mstall_ctrl uut (
        .clk_i(clk), .rst_ni(rst_n), .enable_i(en), .mode_dis_i(mdis),
        .byte_bound_i(bb), .start_i(st), .stop_done_i(spd), .hs_code_i(hsc),
        .tx_empty_i(txe), .rx_full_i(rxf), .receiving_i(rcv),
        .rx_discard_i(disc), .auto_stop_i(aus),
        .busy_o(busy), .stall_o(stall), .stop_req_o(stopr), .hs_sel_o(hs)
    );

    always @(posedge clk) begin
        bit on, hold, endit, look;
        bit n_busy, n_stall, n_stop, n_armed, n_hs;
        if (!rst_n) begin
            m_busy = 0; m_stall = 0; m_stop = 0; m_armed = 0; m_hs = 0;
        end else begin
            on    = en && !mdis;
            hold  = on && ((txe && !aus) || (rcv && !disc && rxf));
            endit = txe && !hold;
            look  = m_busy && !m_stop && (bb || m_stall);
            n_stall = look && hold;
            n_stop  = m_stop || (look && endit);
            n_busy  = m_busy;
            n_armed = m_armed;
            n_hs    = m_hs;
            if (st && m_armed) begin
                n_hs = 1; n_armed = 0;
            end else if (hsc && m_busy) begin
                n_armed = 1;
            end
            if (spd) begin
                n_busy = 0; n_stall = 0; n_stop = 0; n_armed = 0; n_hs = 0;
            end
            if (st) n_busy = 1;
            m_busy = n_busy; m_stall = n_stall; m_stop = n_stop;
            m_armed = n_armed; m_hs = n_hs;
        end
    end

    task automatic cmp(string nm, logic act, bit exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b t=%0t", cur, nm, act, exp, $time);
        end
    endtask

    task automatic tick(int n = 1);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cmp("busy", busy, m_busy);
            cmp("stall", stall, m_stall);
            cmp("stop_req", stopr, m_stop);
            cmp("hs_sel", hs, m_hs);
            bb = 0; st = 0; spd = 0; hsc = 0;
        end
    endtask

    task automatic expect_now(string nm, logic act, bit exp);
        cmp(nm, act, exp);
    endtask

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        cur = "R1";
        tick(3);
        expect_now("reset busy", busy, 0);
        expect_now("reset stall", stall, 0);
        rst_n = 1;
        tick(1);
        expect_now("post reset hs", hs, 0);

        cur = "R2"; en = 1; st = 1; tick(1);
        tick(1); expect_now("busy after start", busy, 1);

        cur = "R3"; txe = 1; tick(2);
        expect_now("no stall without boundary", stall, 0);
        txe = 0; bb = 1; tick(1); tick(1);
        expect_now("continue with data", stall, 0);

        cur = "R4"; txe = 1; bb = 1; tick(1); tick(1);
        expect_now("stall on empty tx", stall, 1);
        cur = "R6"; tick(3);
        expect_now("stall held", stall, 1);
        txe = 0; tick(1); tick(1);
        expect_now("stall released", stall, 0);

        cur = "R5"; rcv = 1; rxf = 1; disc = 1; bb = 1; tick(1); tick(1);
        expect_now("discard no stall", stall, 0);
        disc = 0; bb = 1; tick(1); tick(1);
        expect_now("rx full stall", stall, 1);
        cur = "R6"; rxf = 0; tick(1); tick(1);
        expect_now("rx stall released", stall, 0);
        rcv = 0;

        cur = "R8"; txe = 1; bb = 1; tick(1); tick(1);
        expect_now("stall before disable", stall, 1);
        en = 0; tick(1); tick(1);
        expect_now("disable drops stall", stall, 0);
        expect_now("disable empty stop", stopr, 1);

        cur = "R9"; en = 1; bb = 1; tick(3);
        expect_now("no stall while stop pending", stall, 0);
        expect_now("stop held", stopr, 1);
        spd = 1; tick(1); tick(1);
        expect_now("stop cleared", stopr, 0);
        cur = "R2"; expect_now("busy cleared", busy, 0);

        cur = "R7"; txe = 0; aus = 1; st = 1; tick(1);
        txe = 1; bb = 1; tick(1); tick(1);
        expect_now("auto stop", stopr, 1);
        expect_now("auto stop no stall", stall, 0);
        spd = 1; tick(1);

        cur = "R8"; aus = 0; txe = 0; st = 1; tick(1);
        mdis = 1; bb = 1; tick(1); tick(1);
        expect_now("disabled continue", stopr, 0);
        txe = 1; tick(2);
        expect_now("stop needs boundary", stopr, 0);
        bb = 1; tick(1); tick(1);
        expect_now("disabled stop", stopr, 1);
        spd = 1; tick(1); mdis = 0; txe = 0;

        cur = "R2"; st = 1; spd = 1; tick(1); tick(1);
        expect_now("start wins", busy, 1);

        cur = "R10"; hsc = 1; tick(1); tick(1);
        expect_now("armed not yet", hs, 0);
        st = 1; tick(1); tick(1);
        expect_now("hs after rstart", hs, 1);
        spd = 1; tick(1); tick(1);
        expect_now("hs cleared", hs, 0);
        st = 1; tick(1); tick(1);
        expect_now("plain start normal set", hs, 0);

        cur = "R3";
        for (int k = 0; k < 4000; k++) begin
            en   = ($urandom_range(0, 9) != 0);
            mdis = ($urandom_range(0, 9) == 0);
            txe  = $urandom_range(0, 1);
            rxf  = $urandom_range(0, 1);
            rcv  = $urandom_range(0, 1);
            disc = $urandom_range(0, 1);
            aus  = $urandom_range(0, 1);
            bb   = ($urandom_range(0, 3) == 0);
            st   = ($urandom_range(0, 19) == 0);
            spd  = ($urandom_range(0, 19) == 0);
            hsc  = ($urandom_range(0, 15) == 0);
            tick(1);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule